// File: doc/BRIEF.md
# Serial ADC Acquisition Controller

This block is the host-side master for an 8-bit serial analog-to-digital converter that is reached through four wires: an active-low chip select, a host-generated I/O clock, a serial address line driven toward the converter, and a serial data line returned from it. A request carrying a 4-bit channel number is accepted on a valid/ready handshake. For each request the controller pulls chip select low and waits a setup interval. It then produces eight I/O clock periods, shifting the channel number out MSB first while it gathers the eight bits that the converter returns. Finally it releases chip select and keeps it released for the conversion interval.

The converter only delivers a conversion one access after it was requested, so the byte collected during an access belongs to the channel named in the access before it. The controller keeps the previous channel and tags each returned byte with it. The first byte after reset has no earlier conversion behind it and is flagged. The I/O clock comes from a divider of the core clock with equal high and low phases. The setup and conversion intervals are counted in core clock cycles, and the converter's conversion clock is assumed to run at the core clock rate.

Top module: `adc_acq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, adc_cs_n is 1, adc_ioclk is 0, req_ready is 1 and res_valid is 0.
- R2: At least SETUP_CYC core cycles separate the falling edge of adc_cs_n from the first rising edge of adc_ioclk.
- R3: Each access contains exactly eight adc_ioclk periods, with each high phase and each low phase between edges lasting HALF_DIV core cycles. adc_ioclk is never high while adc_cs_n is high.
- R4: The four channel bits appear on adc_addr MSB first. The bit presented at the n-th rising edge of adc_ioclk (n = 1..4) is channel bit 4-n, and adc_addr never changes in the cycle in which adc_ioclk rises.
- R5: adc_dout is sampled at each rising edge of adc_ioclk. The value taken at the first rising edge becomes bit 7 of res_code and the value at the eighth rising edge becomes bit 0.
- R6: Between the rising edge of adc_cs_n that ends one access and the falling edge that starts the next, adc_cs_n stays high for at least GAP_CYC core cycles.
- R7: res_chan equals the channel of the access before the one that produced the result. res_code is passed through unchanged, including the self-test code obtained with channel 4'b1011.
- R8: The first result after reset carries res_first = 1 and res_chan = 0. Every later result carries res_first = 0.
- R9: req_ready is 0 from the cycle after a request is accepted until the conversion gap has ended. A request held valid during that time is accepted once only.
- R10: res_valid is high for exactly one cycle, and that cycle is the first one in which adc_cs_n is high again after the eighth falling edge of adc_ioclk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_chan | input | 4 | Channel number to convert |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_ioclk | output | 1 | Serial I/O clock to the converter |
| adc_addr | output | 1 | Serial channel address, MSB first |
| adc_dout | input | 1 | Serial result bit from the converter |
| res_valid | output | 1 | One-cycle strobe for a returned result |
| res_code | output | 8 | Returned conversion byte |
| res_chan | output | 4 | Channel that the byte belongs to |
| res_first | output | 1 | Byte has no earlier conversion behind it |

## Verification
Two events can fall in the same cycle. The first is a pending request and the end of the conversion gap, when ready comes back. The second is the eighth falling I/O clock edge together with the release of chip select and the result strobe. The bench holds a request valid through a whole access and its gap. It checks that only one handshake occurs and that the measured high time of chip select still meets the gap. At every result strobe it checks that chip select is already high and was low one cycle earlier. A converter model shifts the captured address into the next result, so every tag and code can be predicted from the request sequence alone.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    localparam int ACQ_CHAN_W = 4;
    localparam int ACQ_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_GAP   = 2'd3
    } acq_state_e;

    typedef struct packed {
        logic [ACQ_DATA_W-1:0] code;
        logic [ACQ_CHAN_W-1:0] chan;
        logic                  first;
    } acq_result_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/acq_phase_gen.sv
module acq_phase_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic io_clk,
    output logic rise_tick,
    output logic fall_tick
);
    logic at_end;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign at_end = run;
        end else begin : g_div
            localparam int CW = $clog2(HALF_DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == CW'(HALF_DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign at_end = run && (cnt == CW'(HALF_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            io_clk <= 1'b0;
        end else if (at_end) begin
            io_clk <= ~io_clk;
        end
    end

    assign rise_tick = at_end && !io_clk;
    assign fall_tick = at_end && io_clk;
endmodule

// File: rtl/acq_shift.sv
module acq_shift #(
    parameter int CHAN_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              din,
    output logic              addr_bit,
    output logic [DATA_W-1:0] code,
    output logic              last_fall
);
    localparam int FW = $clog2(DATA_W + 1);

    logic [CHAN_W-1:0] asr;
    logic [FW-1:0]     fcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            asr  <= '0;
            code <= '0;
            fcnt <= '0;
        end else if (load) begin
            asr  <= chan_in;
            fcnt <= '0;
        end else begin
            if (rise_tick) begin
                code <= {code[DATA_W-2:0], din};
            end
            if (fall_tick) begin
                asr  <= {asr[CHAN_W-2:0], 1'b0};
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    assign addr_bit  = asr[CHAN_W-1];
    assign last_fall = fall_tick && (fcnt == FW'(DATA_W - 1));
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
    import adc_acq_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int SETUP_CYC = 3,
    parameter int GAP_CYC   = 36
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ACQ_CHAN_W-1:0] req_chan,
    output logic                  adc_cs_n,
    output logic                  adc_ioclk,
    output logic                  adc_addr,
    input  logic                  adc_dout,
    output logic                  res_valid,
    output logic [ACQ_DATA_W-1:0] res_code,
    output logic [ACQ_CHAN_W-1:0] res_chan,
    output logic                  res_first
);
    localparam int TMAX = int'(max_of(SETUP_CYC, GAP_CYC));
    localparam int TW   = $clog2(TMAX + 1);

    acq_state_e            state;
    logic [TW-1:0]         tmr;
    logic [ACQ_CHAN_W-1:0] cur_chan;
    logic [ACQ_CHAN_W-1:0] prev_chan;
    logic                  have_prev;
    acq_result_t           res_q;
    logic                  res_vld_q;
    logic                  accept;
    logic                  run;
    logic                  rise_tick;
    logic                  fall_tick;
    logic                  last_fall;
    logic [ACQ_DATA_W-1:0] shift_code;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign run       = (state == ST_XFER);

    acq_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .io_clk    (adc_ioclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    acq_shift #(.CHAN_W(ACQ_CHAN_W), .DATA_W(ACQ_DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .chan_in   (req_chan),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .din       (adc_dout),
        .addr_bit  (adc_addr),
        .code      (shift_code),
        .last_fall (last_fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            adc_cs_n  <= 1'b1;
            tmr       <= '0;
            cur_chan  <= '0;
            prev_chan <= '0;
            have_prev <= 1'b0;
            res_q     <= '0;
            res_vld_q <= 1'b0;
        end else begin
            res_vld_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_SETUP;
                        adc_cs_n <= 1'b0;
                        tmr      <= '0;
                        cur_chan <= req_chan;
                    end
                end
                ST_SETUP: begin
                    tmr <= tmr + 1'b1;
                    if (tmr == TW'(SETUP_CYC - 1)) begin
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (last_fall) begin
                        state       <= ST_GAP;
                        adc_cs_n    <= 1'b1;
                        tmr         <= '0;
                        res_vld_q   <= 1'b1;
                        res_q.code  <= shift_code;
                        res_q.chan  <= prev_chan;
                        res_q.first <= !have_prev;
                        prev_chan   <= cur_chan;
                        have_prev   <= 1'b1;
                    end
                end
                ST_GAP: begin
                    tmr <= tmr + 1'b1;
                    if (tmr == TW'(GAP_CYC - 1)) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign res_valid = res_vld_q;
    assign res_code  = res_q.code;
    assign res_chan  = res_q.chan;
    assign res_first = res_q.first;
endmodule

// File: rtl/adc_acq_ctrl_chk.sv
module adc_acq_ctrl_chk #(
    parameter int SETUP_CYC = 3,
    parameter int GAP_CYC   = 36
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] req_chan,
    input logic       adc_cs_n,
    input logic       adc_ioclk,
    input logic       adc_addr,
    input logic       res_valid,
    input logic [3:0] res_chan,
    input logic       res_first
);
    logic [15:0] gap_cnt;
    logic [15:0] set_cnt;
    logic [3:0]  ck_cur;
    logic [3:0]  ck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= 16'(GAP_CYC);
            set_cnt <= '0;
            ck_cur  <= '0;
            ck_last <= '0;
        end else begin
            if (adc_cs_n) begin
                set_cnt <= '0;
                if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
            end else begin
                gap_cnt <= '0;
                if (set_cnt != 16'hFFFF) set_cnt <= set_cnt + 1'b1;
            end
            if (req_valid && req_ready) ck_cur <= req_chan;
            if (res_valid) ck_last <= ck_cur;
        end
    end

    // R2
    setup_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_ioclk) |-> set_cnt >= 16'(SETUP_CYC));

    // R3
    ioclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        adc_ioclk |-> !adc_cs_n);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_ioclk) |-> $stable(adc_addr));

    // R6
    conv_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> gap_cnt >= 16'(GAP_CYC));

    // R7
    tag_prev_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_first) |-> res_chan == ck_last);

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> adc_cs_n);

    // R10
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $rose(adc_cs_n));
endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk #(
    .SETUP_CYC (SETUP_CYC),
    .GAP_CYC   (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_chan  (req_chan),
    .adc_cs_n  (adc_cs_n),
    .adc_ioclk (adc_ioclk),
    .adc_addr  (adc_addr),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .res_first (res_first)
);

// File: tb/adc_acq_ctrl_test.sv
`timescale 1ns/1ps
module adc_acq_ctrl_test;
    localparam int HALF  = 2;
    localparam int SETUP = 3;
    localparam int GAP   = 36;
    localparam int NV    = 6;
    localparam logic [3:0] CHANS [NV] = '{4'd5, 4'd11, 4'd0, 4'd15, 4'd10, 4'd11};
    localparam logic [7:0] INIT_CODE = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_chan = '0;
    logic       adc_cs_n, adc_ioclk, adc_addr;
    logic       adc_dout = 1'b0;
    logic       res_valid, res_first;
    logic [7:0] res_code;
    logic [3:0] res_chan;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_acq_ctrl #(.HALF_DIV(HALF), .SETUP_CYC(SETUP), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .adc_cs_n(adc_cs_n), .adc_ioclk(adc_ioclk),
        .adc_addr(adc_addr), .adc_dout(adc_dout), .res_valid(res_valid),
        .res_code(res_code), .res_chan(res_chan), .res_first(res_first)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] conv(input logic [3:0] a);
        return (a == 4'd11) ? 8'd128 : {a, ~a};
    endfunction

    // converter model
    logic       m_cs = 1'b1, m_io = 1'b0, gap_free = 1'b1;
    logic [7:0] outreg = INIT_CODE;
    logic [3:0] a_cap = '0, m_last_addr = '0;
    int         rises = 0, falls = 0, t_fall = 0, t_rise = 0, t_io = 0, hs = 0;

    always @(negedge clk) begin
        if (rst) begin
            m_cs = 1'b1; m_io = 1'b0; gap_free = 1'b1;
        end else begin
            if (req_valid && req_ready) hs++;
            if (m_cs && !adc_cs_n) begin
                if (!gap_free) chk(cyc - t_rise >= GAP, "R6", cyc - t_rise, GAP);
                t_fall = cyc; rises = 0; falls = 0; a_cap = '0;
                adc_dout = outreg[7];
            end
            if (!m_io && adc_ioclk) begin
                rises++;
                if (rises == 1) chk(cyc - t_fall >= SETUP, "R2", cyc - t_fall, SETUP);
                else chk(cyc - t_io == HALF, "R3 low phase", cyc - t_io, HALF);
                if (rises <= 4) a_cap = {a_cap[2:0], adc_addr};
                t_io = cyc;
            end
            if (m_io && !adc_ioclk) begin
                falls++;
                chk(cyc - t_io == HALF, "R3 high phase", cyc - t_io, HALF);
                t_io = cyc;
                if (falls < 8) adc_dout = outreg[7-falls];
            end
            if (!m_cs && adc_cs_n) begin
                chk(rises == 8 && falls == 8, "R3 edge count", rises, 8);
                outreg = conv(a_cap); m_last_addr = a_cap;
                t_rise = cyc; gap_free = 1'b0;
            end
            if (adc_ioclk && adc_cs_n) chk(0, "R3 ioclk while deselected", 1, 0);
            m_cs = adc_cs_n; m_io = adc_ioclk;
        end
    end

    task automatic check_reset_state(input string tag);
        chk(adc_cs_n == 1'b1, tag, adc_cs_n, 1);
        chk(adc_ioclk == 1'b0, tag, adc_ioclk, 0);
        chk(req_ready == 1'b1, tag, req_ready, 1);
        chk(res_valid == 1'b0, tag, res_valid, 0);
    endtask

    task automatic wait_result(output bit busy_bad, output bit prev_cs);
        busy_bad = 0; prev_cs = adc_cs_n;
        while (!res_valid) begin
            if (req_ready) busy_bad = 1;
            prev_cs = adc_cs_n;
            @(negedge clk);
        end
    endtask

    task automatic do_access(input logic [3:0] ch, input logic [7:0] ecode,
                             input logic [3:0] echan, input bit efirst, input bit ccode);
        bit busy_bad, prev_cs;
        @(negedge clk); req_valid = 1'b1; req_chan = ch;
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 1'b0;
        wait_result(busy_bad, prev_cs);
        chk(!busy_bad, "R9 ready low while busy", busy_bad, 0);
        chk(adc_cs_n == 1'b1 && prev_cs == 1'b0, "R10 strobe at deselect", adc_cs_n, 1);
        chk(res_first == efirst, "R8 first flag", res_first, efirst);
        chk(res_chan == echan, "R7 tag", res_chan, echan);
        if (ccode) chk(res_code == ecode, "R5 code", res_code, ecode);
        @(negedge clk);
        chk(res_valid == 1'b0, "R10 one-cycle strobe", res_valid, 0);
        chk(m_last_addr == ch, "R4 address", m_last_addr, ch);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("R1 after reset");

        // table walk: each result tags and carries the previous channel
        for (int i = 0; i < NV; i++) begin
            if (i == 0) do_access(CHANS[i], INIT_CODE, 4'd0, 1'b1, 1'b1);
            else        do_access(CHANS[i], conv(CHANS[i-1]), CHANS[i-1], 1'b0, 1'b1);
        end

        // held request across the access and its gap (R9, R6)
        begin
            bit busy_bad, prev_cs;
            int hs0;
            hs0 = hs;
            @(negedge clk); req_valid = 1'b1; req_chan = 4'd7;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            wait_result(busy_bad, prev_cs);
            chk(hs - hs0 == 1, "R9 single accept", hs - hs0, 1);
            chk(res_code == 8'd128, "R7 self-test code", res_code, 128);
            chk(res_chan == 4'd11, "R7 self-test tag", res_chan, 11);
            repeat (GAP - 4) @(negedge clk);
            chk(hs - hs0 == 1, "R9 still one accept in gap", hs - hs0, 1);
            while (!req_ready) @(negedge clk);
            @(negedge clk); req_valid = 1'b0;
            wait_result(busy_bad, prev_cs);
            chk(res_chan == 4'd7 && res_code == conv(4'd7), "R7 back-to-back", res_chan, 7);
            @(negedge clk);
        end

        // reset in the middle of an access
        @(negedge clk); req_valid = 1'b1; req_chan = 4'd3;
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 1'b0;
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("R1 mid-access reset");
        rst = 1'b0;
        do_access(4'd9, 8'h00, 4'd0, 1'b1, 1'b0);
        do_access(4'd2, conv(4'd9), 4'd9, 1'b0, 1'b1);
        do_access(4'd11, conv(4'd2), 4'd2, 1'b0, 1'b1);

        repeat (GAP + 4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule